// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the byte-wide programming port of a single eight-line interrupt controller. Software writes and reads bytes through a one-bit register address (`a0`), a write strobe and a read strobe. Writes are decoded from the address and the data bits into three groups. The first is a three- or four-word initialization sequence. The second is a group of mode commands covering poll, register read select and special mask. The third is a family of eight command codes for end-of-interrupt, rotation and priority offset. The sequencer holds the interrupt mask, the in-service set, the vector base, the priority rotation offset and the mode flags. Neighbouring logic reads these registers directly.

Request capture and priority resolution among pending requests live outside this block. The block reads the request register on `irr_in` and receives the winning line from the resolver on `win_valid`/`win_line`. It returns a per-line clear strobe on `irr_clr`. An acknowledge input from the interrupt cycle adds a line to the in-service set. Under automatic end-of-interrupt, that acknowledge can instead advance the rotation offset. A poll-mode read reports the winning line and retires it in the same access.

Top module: `irqseq_top`

## Requirements
- R1: After reset, mask, in-service set, vector base, offset, all mode flags and the init step (`init_step`, 0 = normal, 1 = expecting base, 2 = expecting cascade word, 3 = expecting mode word) are zero.
- R2: A write with `a0`=0 and data bit 4 set starts initialization. In that cycle `int_drop` is 1 and `irr_clr` is 8'hFF. After the edge, mask, in-service set, offset, base, poll, read select, special mask, auto-EOI, nested and rotate-on-auto-EOI are 0, `init_step` is 1, and data bit 0 is kept as "mode word needed".
- R3: In step 1, an `a0`=1 write sets `base_q` to data AND 8'hF8 and moves to step 2.
- R4: In step 2, an `a0`=1 write changes nothing except the step, which becomes 3 if the mode word is needed and 0 otherwise.
- R5: In step 3, an `a0`=1 write sets `nested_q` from data bit 4 and `auto_eoi_q` from data bit 1, then returns to step 0.
- R6: In step 0, an `a0`=1 write loads the mask from the data byte.
- R7: A write with `a0`=0, bit 4 clear and bit 3 set does three things. If bit 2 is set, it arms poll mode. If bit 1 is set, it loads read select from bit 0. If bit 6 is set, it loads `smask_q` from bit 5.
- R8: Other `a0`=0 writes decode data bits 7..5 as a command code. Codes 0 and 4 load `rot_aeoi_q` from bit 7. Code 2 changes nothing.
- R9: Codes 1 and 5 clear the highest-priority in-service bit. Priority starts at line `offset_q` and rises modulo 8. Code 5 also sets the offset to that line + 1 (mod 8). With an empty in-service set, neither code changes anything.
- R10: Code 3 clears the in-service bit named by data bits 2..0. Code 7 does the same and also sets the offset to that line + 1 (mod 8).
- R11: Code 6 sets the offset to data bits 2..0 + 1 (mod 8).
- R12: When poll mode is not armed, a read changes no register. `rdata` is the in-service set for `a0`=0 with read select set, `irr_in` for `a0`=0 with read select clear, and the mask for `a0`=1.
- R13: With poll mode armed, `rdata` is `win_line` if `win_valid` is set and 7 otherwise. On a read with a winner, `irr_clr` has only the winner's bit set and the edge clears that in-service bit. Poll mode is disarmed after one read.
- R14: An `ack_en` pulse sets in-service bit `ack_line` while auto-EOI is off. With auto-EOI on, the in-service set is untouched, and the offset becomes `ack_line` + 1 when rotate-on-auto-EOI is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, acts on the rising edge |
| rd_en | input | 1 | Read strobe |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irr_in | input | 8 | Request register from capture logic |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | 3 | Winning line number |
| ack_en | input | 1 | Interrupt acknowledge pulse |
| ack_line | input | 3 | Acknowledged line |
| irr_clr | output | 8 | Per-line request clear strobes |
| int_drop | output | 1 | Forces the interrupt output low (init) |
| init_step | output | 2 | Init sequence step |
| mask_q | output | 8 | Interrupt mask |
| isr_q | output | 8 | In-service set |
| base_q | output | 8 | Vector base |
| offset_q | output | 3 | Priority rotation offset |
| auto_eoi_q | output | 1 | Automatic end-of-interrupt |
| nested_q | output | 1 | Special fully nested mode |
| smask_q | output | 1 | Special mask mode |
| rot_aeoi_q | output | 1 | Rotate on automatic end-of-interrupt |

## Verification
The assertions assume that a write never shares a cycle with a read or with an acknowledge. Every register therefore has a single source of change per edge. The bench drives each access as a one-cycle strobe on the falling edge and releases it before issuing the next, so the three strobes never overlap. The resolver inputs are treated as a free choice of the bench. The checks therefore do not assume that `win_line` agrees with `irr_in` or the mask.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  localparam int NLINE = 8;
  localparam int LW    = $clog2(NLINE);

  typedef enum logic [1:0] {
    STEP_NORMAL  = 2'd0,
    STEP_BASE    = 2'd1,
    STEP_CASCADE = 2'd2,
    STEP_MODE    = 2'd3
  } step_e;

  // one-hot-ish classification of a single write access
  typedef struct packed {
    logic init;      // first init word
    logic base_w;    // vector base word
    logic casc_w;    // cascade word (consumed)
    logic mode_w;    // mode word
    logic mask_w;    // mask load
    logic ocw3;      // poll / read select / special mask
    logic rot_w;     // rotate-on-auto-EOI load
    logic eoi_top;   // clear highest-priority in-service bit
    logic eoi_sel;   // clear named in-service bit
    logic set_off;   // set offset directly
    logic rot_after; // eoi also moves offset
  } wdec_t;

endpackage

// File: rtl/irqseq_decode.sv
module irqseq_decode
  import irqseq_pkg::*;
(
  input  logic       wr_en,
  input  logic       a0,
  input  logic [4:0] cmd_bits,   // data bits 7..3
  input  step_e      step,
  output wdec_t      dec
);

  logic [2:0] code;
  assign code = cmd_bits[4:2];

  always_comb begin
    dec = '0;
    if (wr_en) begin
      if (!a0) begin
        if (cmd_bits[1]) begin
          dec.init = 1'b1;
        end else if (cmd_bits[0]) begin
          dec.ocw3 = 1'b1;
        end else begin
          unique case (code)
            3'd0, 3'd4: dec.rot_w   = 1'b1;
            3'd1:       dec.eoi_top = 1'b1;
            3'd5: begin dec.eoi_top = 1'b1; dec.rot_after = 1'b1; end
            3'd3:       dec.eoi_sel = 1'b1;
            3'd7: begin dec.eoi_sel = 1'b1; dec.rot_after = 1'b1; end
            3'd6:       dec.set_off = 1'b1;
            default: ;  // code 2: no operation
          endcase
        end
      end else begin
        unique case (step)
          STEP_NORMAL:  dec.mask_w = 1'b1;
          STEP_BASE:    dec.base_w = 1'b1;
          STEP_CASCADE: dec.casc_w = 1'b1;
          STEP_MODE:    dec.mode_w = 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irqseq_init_fsm.sv
module irqseq_init_fsm
  import irqseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wdec_t      dec,
  input  logic [4:0] d_base,     // data bits 7..3
  input  logic       d_need4,    // data bit 0
  input  logic       d_nested,   // data bit 4
  input  logic       d_aeoi,     // data bit 1
  output step_e      step,
  output logic [7:0] base,
  output logic       nested,
  output logic       aeoi
);

  step_e      step_q, step_n;
  logic       need4_q, need4_n;
  logic [4:0] base_q, base_n;
  logic       nest_q, nest_n;
  logic       aeoi_q, aeoi_n;
  logic       en;

  assign en = dec.init | dec.base_w | dec.casc_w | dec.mode_w;

  always_comb begin
    step_n  = step_q;
    need4_n = need4_q;
    base_n  = base_q;
    nest_n  = nest_q;
    aeoi_n  = aeoi_q;
    if (dec.init) begin
      step_n  = STEP_BASE;
      need4_n = d_need4;
      base_n  = '0;
      nest_n  = 1'b0;
      aeoi_n  = 1'b0;
    end else if (dec.base_w) begin
      base_n  = d_base;
      step_n  = STEP_CASCADE;
    end else if (dec.casc_w) begin
      step_n  = need4_q ? STEP_MODE : STEP_NORMAL;
    end else if (dec.mode_w) begin
      nest_n  = d_nested;
      aeoi_n  = d_aeoi;
      step_n  = STEP_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= STEP_NORMAL;
      need4_q <= 1'b0;
      base_q  <= '0;
      nest_q  <= 1'b0;
      aeoi_q  <= 1'b0;
    end else if (en) begin
      step_q  <= step_n;
      need4_q <= need4_n;
      base_q  <= base_n;
      nest_q  <= nest_n;
      aeoi_q  <= aeoi_n;
    end
  end

  assign step   = step_q;
  assign base   = {base_q, 3'b000};
  assign nested = nest_q;
  assign aeoi   = aeoi_q;

  AST_INIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec.init |=> step_q == STEP_BASE); // R2

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dec.base_w |=> (base == {$past(d_base), 3'b000}) && step_q == STEP_CASCADE); // R3

  AST_CASC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec.casc_w |=> step_q == ($past(need4_q) ? STEP_MODE : STEP_NORMAL)); // R4

  AST_MODE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dec.mode_w |=> step_q == STEP_NORMAL && aeoi_q == $past(d_aeoi)); // R5

endmodule

// File: rtl/irqseq_isr.sv
module irqseq_isr
  import irqseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  wdec_t         dec,
  input  logic [LW-1:0] d_line,     // data bits 2..0
  input  logic          ack_en,
  input  logic [LW-1:0] ack_line,
  input  logic          aeoi,
  input  logic          rot_aeoi,
  input  logic          poll_hit,
  input  logic [LW-1:0] poll_line,
  output logic [NLINE-1:0] isr,
  output logic [LW-1:0]    offset
);

  logic [NLINE-1:0] isr_q, isr_n, line_oh, ack_oh, poll_oh;
  logic [LW-1:0]    off_q, off_n, top_line;
  logic             top_valid, en;

  // highest-priority set bit, scanning upward from the offset
  always_comb begin
    top_valid = 1'b0;
    top_line  = '0;
    for (int k = NLINE - 1; k >= 0; k--) begin
      if (isr_q[off_q + LW'(k)]) begin
        top_valid = 1'b1;
        top_line  = off_q + LW'(k);
      end
    end
  end

  for (genvar g = 0; g < NLINE; g++) begin : g_oh
    assign line_oh[g] = (d_line    == LW'(g));
    assign ack_oh[g]  = (ack_line  == LW'(g));
    assign poll_oh[g] = (poll_line == LW'(g));
  end

  always_comb begin
    isr_n = isr_q;
    off_n = off_q;
    if (dec.init) begin
      isr_n = '0;
      off_n = '0;
    end else if (dec.eoi_top) begin
      if (top_valid) begin
        isr_n[top_line] = 1'b0;
        if (dec.rot_after) off_n = top_line + 1'b1;
      end
    end else if (dec.eoi_sel) begin
      isr_n = isr_q & ~line_oh;
      if (dec.rot_after) off_n = d_line + 1'b1;
    end else if (dec.set_off) begin
      off_n = d_line + 1'b1;
    end else if (ack_en) begin
      if (!aeoi)         isr_n = isr_q | ack_oh;
      else if (rot_aeoi) off_n = ack_line + 1'b1;
    end
    if (poll_hit) isr_n = isr_n & ~poll_oh;
  end

  assign en = dec.init | dec.eoi_top | dec.eoi_sel | dec.set_off | ack_en | poll_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      off_q <= '0;
    end else if (en) begin
      isr_q <= isr_n;
      off_q <= off_n;
    end
  end

  assign isr    = isr_q;
  assign offset = off_q;

  AST_EOI_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.eoi_top || dec.eoi_sel) |=> $countones(isr_q) <= $countones($past(isr_q))); // R10

  AST_EOI_ONE_LESS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.eoi_top && isr_q != '0) |=> $countones(isr_q) + 1 == $countones($past(isr_q))); // R9

  AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !aeoi && !dec.init && !poll_hit) |=> isr_q[$past(ack_line)]); // R14

  AST_OFFSET_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dec.set_off |=> off_q == $past(d_line) + 1'b1); // R11

endmodule

// File: rtl/irqseq_top.sv
module irqseq_top
  import irqseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       a0,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irr_in,
  input  logic       win_valid,
  input  logic [2:0] win_line,
  input  logic       ack_en,
  input  logic [2:0] ack_line,
  output logic [7:0] irr_clr,
  output logic       int_drop,
  output logic [1:0] init_step,
  output logic [7:0] mask_q,
  output logic [7:0] isr_q,
  output logic [7:0] base_q,
  output logic [2:0] offset_q,
  output logic       auto_eoi_q,
  output logic       nested_q,
  output logic       smask_q,
  output logic       rot_aeoi_q
);

  wdec_t      dec;
  step_e      step;
  logic [7:0] mask_r, mask_n;
  logic       rsel_r, rsel_n, poll_r, poll_n, smask_r, smask_n, rot_r, rot_n;
  logic       poll_rd, poll_hit, en;

  irqseq_decode u_dec (
    .wr_en    (wr_en),
    .a0       (a0),
    .cmd_bits (wdata[7:3]),
    .step     (step),
    .dec      (dec)
  );

  irqseq_init_fsm u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .d_base   (wdata[7:3]),
    .d_need4  (wdata[0]),
    .d_nested (wdata[4]),
    .d_aeoi   (wdata[1]),
    .step     (step),
    .base     (base_q),
    .nested   (nested_q),
    .aeoi     (auto_eoi_q)
  );

  irqseq_isr u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .d_line    (wdata[2:0]),
    .ack_en    (ack_en),
    .ack_line  (ack_line),
    .aeoi      (auto_eoi_q),
    .rot_aeoi  (rot_r),
    .poll_hit  (poll_hit),
    .poll_line (win_line),
    .isr       (isr_q),
    .offset    (offset_q)
  );

  assign poll_rd  = rd_en & poll_r;
  assign poll_hit = poll_rd & win_valid;

  always_comb begin
    mask_n  = mask_r;
    rsel_n  = rsel_r;
    poll_n  = poll_r;
    smask_n = smask_r;
    rot_n   = rot_r;
    if (dec.init) begin
      mask_n  = '0;
      rsel_n  = 1'b0;
      poll_n  = 1'b0;
      smask_n = 1'b0;
      rot_n   = 1'b0;
    end else if (dec.mask_w) begin
      mask_n = wdata;
    end else if (dec.ocw3) begin
      if (wdata[2]) poll_n  = 1'b1;
      if (wdata[1]) rsel_n  = wdata[0];
      if (wdata[6]) smask_n = wdata[5];
    end else if (dec.rot_w) begin
      rot_n = wdata[7];
    end else if (poll_rd) begin
      poll_n = 1'b0;
    end
  end

  assign en = dec.init | dec.mask_w | dec.ocw3 | dec.rot_w | poll_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r  <= '0;
      rsel_r  <= 1'b0;
      poll_r  <= 1'b0;
      smask_r <= 1'b0;
      rot_r   <= 1'b0;
    end else if (en) begin
      mask_r  <= mask_n;
      rsel_r  <= rsel_n;
      poll_r  <= poll_n;
      smask_r <= smask_n;
      rot_r   <= rot_n;
    end
  end

  always_comb begin
    if (poll_r)      rdata = win_valid ? {5'b0, win_line} : 8'd7;
    else if (a0)     rdata = mask_r;
    else if (rsel_r) rdata = isr_q;
    else             rdata = irr_in;
  end

  always_comb begin
    irr_clr = '0;
    if (dec.init)     irr_clr = '1;
    else if (poll_hit) irr_clr[win_line] = 1'b1;
  end

  assign int_drop   = dec.init;
  assign init_step  = step;
  assign mask_q     = mask_r;
  assign smask_q    = smask_r;
  assign rot_aeoi_q = rot_r;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a0 && step == STEP_NORMAL) |=> mask_r == $past(wdata)); // R6

  AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_r && !wr_en) |=> !poll_r); // R13

  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R12

  AST_WR_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && ack_en)); // R14

  AST_PLAIN_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !poll_r && !wr_en && !ack_en) |=> $stable(isr_q) && $stable(mask_r)); // R12

endmodule

// File: tb/irqseq_top_test.sv
`timescale 1ns/1ps
module irqseq_top_test;

  logic       clk, rst_n, wr_en, rd_en, a0, win_valid, ack_en;
  logic [7:0] wdata, rdata, irr_in, irr_clr, mask_q, isr_q, base_q;
  logic [2:0] win_line, ack_line, offset_q;
  logic [1:0] init_step;
  logic       int_drop, auto_eoi_q, nested_q, smask_q, rot_aeoi_q;

  int n_chk = 0;
  int n_bad = 0;

  irqseq_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .a0(a0),
    .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .win_valid(win_valid),
    .win_line(win_line), .ack_en(ack_en), .ack_line(ack_line),
    .irr_clr(irr_clr), .int_drop(int_drop), .init_step(init_step),
    .mask_q(mask_q), .isr_q(isr_q), .base_q(base_q), .offset_q(offset_q),
    .auto_eoi_q(auto_eoi_q), .nested_q(nested_q), .smask_q(smask_q),
    .rot_aeoi_q(rot_aeoi_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic adr, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; a0 = adr; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack(input logic [2:0] ln);
    @(negedge clk);
    ack_en = 1'b1; ack_line = ln;
    @(negedge clk);
    ack_en = 1'b0;
  endtask

  // read: rdata and irr_clr sampled mid-cycle, before the edge
  task automatic rd(input logic adr, output logic [7:0] v, output logic [7:0] clr);
    @(negedge clk);
    rd_en = 1'b1; a0 = adr;
    #1 v = rdata; clr = irr_clr;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic full_init(input logic [7:0] w1, input logic [7:0] w2,
                           input logic [7:0] w3, input logic [7:0] w4);
    wr(1'b0, w1); wr(1'b1, w2); wr(1'b1, w3);
    if (w1[0]) wr(1'b1, w4);
  endtask

  task automatic t_reset;
    chk("R1 mask", mask_q, 0);      chk("R1 isr", isr_q, 0);
    chk("R1 base", base_q, 0);      chk("R1 offset", offset_q, 0);
    chk("R1 step", init_step, 0);
    chk("R1 flags", {auto_eoi_q, nested_q, smask_q, rot_aeoi_q}, 0);
  endtask

  task automatic t_init;
    // dirty some state first
    wr(1'b1, 8'h3C); wr(1'b0, 8'h68); wr(1'b0, 8'h80); wr(1'b0, 8'hC2);
    ack(3'd1);
    // first word with mode word needed; check strobes during the write
    @(negedge clk);
    wr_en = 1'b1; a0 = 1'b0; wdata = 8'h11;
    #1 chk("R2 int_drop", int_drop, 1); chk("R2 irr_clr", irr_clr, 8'hFF);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 step", init_step, 1);   chk("R2 mask", mask_q, 0);
    chk("R2 isr", isr_q, 0);        chk("R2 offset", offset_q, 0);
    chk("R2 flags", {smask_q, rot_aeoi_q}, 0);
    wr(1'b1, 8'h4F);
    chk("R3 base", base_q, 8'h48);  chk("R3 step", init_step, 2);
    wr(1'b1, 8'hAA);
    chk("R4 step mode", init_step, 3); chk("R4 base kept", base_q, 8'h48);
    wr(1'b1, 8'h12);
    chk("R5 nested", nested_q, 1);  chk("R5 aeoi", auto_eoi_q, 1);
    chk("R5 step", init_step, 0);
    // three-word form
    full_init(8'h10, 8'h27, 8'h00, 8'h00);
    chk("R3 base 3w", base_q, 8'h20);
    chk("R4 step normal", init_step, 0);
    chk("R2 aeoi cleared", auto_eoi_q, 0);
  endtask

  task automatic t_mask;
    logic [7:0] v, c;
    wr(1'b1, 8'h5A);
    chk("R6 mask", mask_q, 8'h5A);
    rd(1'b1, v, c);
    chk("R12 read mask", v, 8'h5A);
  endtask

  task automatic t_eoi;
    full_init(8'h11, 8'h08, 8'h00, 8'h00);
    ack(3'd3); ack(3'd5); ack(3'd6);
    chk("R14 ack sets", isr_q, 8'h68);
    wr(1'b0, 8'h20);
    chk("R9 eoi lowest", isr_q, 8'h60);
    wr(1'b0, 8'hC4);
    chk("R11 offset", offset_q, 5);
    wr(1'b0, 8'hA0);
    chk("R9 rot eoi isr", isr_q, 8'h40); chk("R9 rot eoi off", offset_q, 6);
    wr(1'b0, 8'h66);
    chk("R10 specific", isr_q, 8'h00);
    ack(3'd2); ack(3'd0);
    wr(1'b0, 8'hE2);
    chk("R10 spec rot isr", isr_q, 8'h01); chk("R10 spec rot off", offset_q, 3);
    wr(1'b0, 8'h60);
    wr(1'b0, 8'h20);
    chk("R9 empty isr", isr_q, 0);  chk("R9 empty off", offset_q, 3);
    wr(1'b0, 8'hA0);
    chk("R9 empty rot off", offset_q, 3);
    wr(1'b0, 8'hC7);
    chk("R11 wrap", offset_q, 0);
    // with offset 6, line 7 outranks line 1
    wr(1'b0, 8'hC5); ack(3'd1); ack(3'd7);
    wr(1'b0, 8'h20);
    chk("R9 rotated order", isr_q, 8'h02);
  endtask

  task automatic t_ocw3;
    logic [7:0] v, c;
    full_init(8'h11, 8'h08, 8'h00, 8'h00);
    ack(3'd4); ack(3'd1);
    irr_in = 8'h93;
    rd(1'b0, v, c);
    chk("R12 read irr", v, 8'h93);
    wr(1'b0, 8'h0B);
    rd(1'b0, v, c);
    chk("R7 rsel isr", v, 8'h12);
    chk("R12 read keeps isr", isr_q, 8'h12);
    wr(1'b0, 8'h68);
    chk("R7 smask on", smask_q, 1);
    wr(1'b0, 8'h28);
    chk("R7 smask kept", smask_q, 1);
    wr(1'b0, 8'h48);
    chk("R7 smask off", smask_q, 0);
    wr(1'b0, 8'h0C);
    win_valid = 1'b1; win_line = 3'd4;
    rd(1'b1, v, c);
    chk("R13 poll value", v, 4);    chk("R13 poll clr", c, 8'h10);
    chk("R13 poll isr", isr_q, 8'h02);
    rd(1'b0, v, c);
    chk("R13 one shot", v, 8'h02);
    wr(1'b0, 8'h0C);
    win_valid = 1'b0;
    rd(1'b0, v, c);
    chk("R13 no winner", v, 7);     chk("R13 no clr", c, 0);
    wr(1'b0, 8'h0A);
    rd(1'b0, v, c);
    chk("R7 rsel off", v, 8'h93);
  endtask

  task automatic t_rot;
    wr(1'b0, 8'h80);
    chk("R8 rot on", rot_aeoi_q, 1);
    wr(1'b0, 8'h40);
    chk("R8 code2 rot", rot_aeoi_q, 1); chk("R8 code2 isr", isr_q, 8'h02);
    chk("R8 code2 off", offset_q, 0);
    wr(1'b0, 8'h00);
    chk("R8 rot off", rot_aeoi_q, 0);
    full_init(8'h11, 8'h08, 8'h00, 8'h02);
    wr(1'b0, 8'h80);
    ack(3'd4);
    chk("R14 aeoi isr", isr_q, 0);  chk("R14 aeoi rot", offset_q, 5);
    wr(1'b0, 8'h00);
    ack(3'd1);
    chk("R14 aeoi no rot", offset_q, 5);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; a0 = 1'b0; wdata = '0;
    irr_in = '0; win_valid = 1'b0; win_line = '0; ack_en = 1'b0; ack_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init();
    t_mask();
    t_eoi();
    t_ocw3();
    t_rot();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule